// File: doc/BRIEF.md
# Cross-Triggering Delay Channel Scheduler

This block holds four programmable countdown channels that decide when eight downstream converter channels are asked to sample. Each channel has one 32-bit control word. The word holds a countdown value, a repeat count, a mask of converter targets and a mask of delay-channel targets. A start bit in the word launches the countdown. The countdown advances only on a slow timebase enable, which arrives as a one-cycle pulse. When a countdown expires, the channel posts requests to every converter in its converter mask by setting bits in a sticky 8-bit schedule vector. The converters clear those bits through a per-bit clear input.

At the same moment, the channel starts every delay channel in its delay mask, and this may include the channel itself. Channels can therefore be chained into dependent sequences, or left to re-arm themselves indefinitely. A non-zero repeat count makes the channel reload its countdown and run again on its own. Each run lowers the repeat field by one, so a repeat count of N gives N+1 events.

Software reaches the control words through a word-addressed write port. The address selects a channel and one of four write flavours: plain write, bit set, bit clear and bit toggle. A combinational read port returns any channel's word, and one busy flag per channel shows which countdowns are running.

Top module: `xtrig_delay_bank`

## Requirements
- R1: After reset, every control word reads 0x00000000, `schedule` is 0 and `chanBusy` is 0.
- R2: `wrAddr[3:2]` selects the channel, so the byte offset is 0x10 times the channel. `wrAddr[1:0]` selects the operation: 0 writes the data, 1 ORs it in, 2 clears the bits that are one in the data, and 3 XORs it in. Word fields are: converter mask [31:24], delay-channel mask [19:16], repeat count [15:11] and countdown [10:0]. Bits [23:21] always read 0.
- R3: The start bit is bit 20. If a write leaves bit 20 at one, the channel is busy from the next cycle and the countdown is loaded. Bit 20 always reads back as 0. A clear-flavour write never starts a channel.
- R4: A countdown of D≥1 expires on the D-th `tickEn` pulse after the start. A countdown of 0 expires on the first pulse. Without a `tickEn` pulse, no `schedule` bit rises.
- R5: An expiry sets the `schedule` bits chosen by the converter mask in the following cycle. A set bit stays set until its `schedClr` bit is one, and it is 0 in the cycle after that.
- R6: An expiry starts every delay channel in its delay mask, with the same effect as a start-bit write. Several targets may start at once.
- R7: A channel whose delay mask includes itself restarts at each expiry and produces an event every D pulses.
- R8: A repeat count of N produces N+1 expiries, D pulses apart. The repeat field reads one lower after each non-final expiry.
- R9: After its final expiry, a channel that is not retriggered goes idle, and `chanBusy` drops to 0.
- R10: Expiries of several channels on the same pulse are OR-combined, both into `schedule` and into the delay-channel starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle timebase pulse for countdowns |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 4 | Word address: [3:2] channel, [1:0] write flavour |
| wrData | input | 32 | Write data |
| rdChan | input | 2 | Channel whose word appears on rdData |
| rdData | output | 32 | Control word of channel rdChan |
| schedClr | input | 8 | Per-bit clear of the schedule vector |
| schedule | output | 8 | Sticky converter request bits |
| chanBusy | output | 4 | Countdown running, one bit per channel |

## Verification
The assertions take three things for granted about the inputs. `tickEn` is the only source of expiries. A write is applied in the cycle its strobe is high. `schedClr` is driven by the consumer, so a bit with no clear is never dropped. The bench spaces `tickEn` pulses at least three cycles apart, so successive events on one schedule bit stay distinct. It holds `schedClr` all-ones except during the sticky-bit test, so each event appears as a single rising edge. It drives writes only between pulses, except where a stop write deliberately lands while a channel is running.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int NUM_CHAN  = 4;
  localparam int NUM_CONV  = 8;
  localparam int CNT_W     = 11;
  localparam int LOOP_W    = 5;
  localparam int DATA_W    = 32;
  localparam int CH_IDX_W  = $clog2(NUM_CHAN);
  localparam int ADDR_W    = CH_IDX_W + 2;

  // field positions of the control word
  localparam int CNT_LSB   = 0;
  localparam int LOOP_LSB  = CNT_LSB + CNT_W;
  localparam int CHM_LSB   = 16;
  localparam int KICK_BIT  = 20;
  localparam int CNV_LSB   = 24;

  // bits kept in storage: masks, repeat count, countdown
  localparam logic [DATA_W-1:0] STORE_MASK =
      (DATA_W'((1 << NUM_CONV) - 1) << CNV_LSB) |
      (DATA_W'((1 << NUM_CHAN) - 1) << CHM_LSB) |
      (DATA_W'((1 << LOOP_W) - 1) << LOOP_LSB) |
      (DATA_W'((1 << CNT_W) - 1) << CNT_LSB);

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_FLIP  = 2'd3
  } wrOp_t;

  typedef struct packed {
    logic start;    // load countdown, go busy
    logic reload;   // repeat: reload countdown
    logic dec;      // decrement countdown
    logic loopDec;  // lower repeat field
    logic fire;     // expiry this cycle
  } chanStrobe_t;

  function automatic logic [DATA_W-1:0] applyOp(input logic [DATA_W-1:0] cur,
                                                input logic [DATA_W-1:0] data,
                                                input wrOp_t op);
    case (op)
      OP_WRITE: applyOp = data;
      OP_SET:   applyOp = cur | data;
      OP_CLEAR: applyOp = cur & ~data;
      default:  applyOp = cur ^ data;
    endcase
  endfunction
endpackage

// File: rtl/xtrig_control.sv
module xtrig_control
  import xtrig_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               tickEn,
  input  logic [NUM_CHAN-1:0]                kickReq,
  input  logic [NUM_CHAN-1:0]                cntLow,
  input  logic [NUM_CHAN-1:0]                loopsZero,
  input  logic [NUM_CHAN-1:0][NUM_CHAN-1:0]  chanMask,
  output chanStrobe_t [NUM_CHAN-1:0]         strobe,
  output logic [NUM_CHAN-1:0]                busy
);
  logic [NUM_CHAN-1:0] busyQ, busyD;
  logic [NUM_CHAN-1:0] fire, trigIn, start;

  always_comb begin
    for (int c = 0; c < NUM_CHAN; c++)
      fire[c] = busyQ[c] & tickEn & cntLow[c];
  end

  // cross-trigger fabric: OR of every source's request per target
  always_comb begin
    trigIn = '0;
    for (int src = 0; src < NUM_CHAN; src++)
      if (fire[src]) trigIn = trigIn | chanMask[src];
  end

  assign start = kickReq | trigIn;

  always_comb begin
    for (int c = 0; c < NUM_CHAN; c++) begin
      strobe[c].fire    = fire[c];
      strobe[c].start   = start[c];
      strobe[c].loopDec = fire[c] & ~loopsZero[c];
      strobe[c].reload  = fire[c] & ~loopsZero[c] & ~start[c];
      strobe[c].dec     = busyQ[c] & tickEn & ~cntLow[c] & ~start[c];
      if (start[c])
        busyD[c] = 1'b1;
      else if (fire[c] && loopsZero[c])
        busyD[c] = 1'b0;
      else
        busyD[c] = busyQ[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busyQ <= '0;
    else       busyQ <= busyD;
  end

  assign busy = busyQ;
endmodule

// File: rtl/xtrig_datapath.sv
module xtrig_datapath
  import xtrig_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               wrEn,
  input  logic [ADDR_W-1:0]                  wrAddr,
  input  logic [DATA_W-1:0]                  wrData,
  input  logic [CH_IDX_W-1:0]                rdChan,
  output logic [DATA_W-1:0]                  rdData,
  input  logic [NUM_CONV-1:0]                schedClr,
  input  chanStrobe_t [NUM_CHAN-1:0]         strobe,
  output logic [NUM_CHAN-1:0]                kickReq,
  output logic [NUM_CHAN-1:0]                cntLow,
  output logic [NUM_CHAN-1:0]                loopsZero,
  output logic [NUM_CHAN-1:0][NUM_CHAN-1:0]  chanMask,
  output logic [NUM_CONV-1:0]                schedule
);
  wrOp_t                  wrOp;
  logic [CH_IDX_W-1:0]    wrChan;
  logic [DATA_W-1:0]      wordQ [NUM_CHAN];
  logic [NUM_CONV-1:0]    convReq [NUM_CHAN];

  assign wrOp   = wrOp_t'(wrAddr[1:0]);
  assign wrChan = wrAddr[ADDR_W-1:2];

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic [DATA_W-1:0] opWord, wordD;
    logic [CNT_W-1:0]  countQ, countD, loadVal;
    logic [LOOP_W-1:0] loopsQ;
    logic              wrHit;

    assign wrHit  = wrEn && (wrChan == CH_IDX_W'(c));
    assign opWord = applyOp(wordQ[c], wrData, wrOp);
    assign loopsQ = wordQ[c][LOOP_LSB +: LOOP_W];

    always_comb begin
      wordD = wordQ[c];
      if (wrHit)
        wordD = opWord & STORE_MASK;
      else if (strobe[c].loopDec)
        wordD[LOOP_LSB +: LOOP_W] = loopsQ - LOOP_W'(1);
    end

    assign loadVal = wordD[CNT_LSB +: CNT_W];

    always_comb begin
      if (strobe[c].start || strobe[c].reload)
        countD = loadVal;
      else if (strobe[c].dec)
        countD = countQ - CNT_W'(1);
      else
        countD = countQ;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wordQ[c] <= '0;
        countQ   <= '0;
      end else begin
        wordQ[c] <= wordD;
        countQ   <= countD;
      end
    end

    assign kickReq[c]   = wrHit && opWord[KICK_BIT];
    assign cntLow[c]    = countQ <= CNT_W'(1);
    assign loopsZero[c] = loopsQ == '0;
    assign chanMask[c]  = wordQ[c][CHM_LSB +: NUM_CHAN];
    assign convReq[c]   = strobe[c].fire ? wordQ[c][CNV_LSB +: NUM_CONV] : '0;
  end

  logic [NUM_CONV-1:0] schedQ, schedSet;

  always_comb begin
    schedSet = '0;
    for (int c = 0; c < NUM_CHAN; c++)
      schedSet = schedSet | convReq[c];
  end

  always_ff @(posedge clk) begin
    if (!rstN) schedQ <= '0;
    else       schedQ <= (schedQ & ~schedClr) | schedSet;
  end

  assign schedule = schedQ;
  assign rdData   = wordQ[rdChan];
endmodule

// File: rtl/xtrig_delay_bank.sv
module xtrig_delay_bank
  import xtrig_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [CH_IDX_W-1:0] rdChan,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_CONV-1:0] schedClr,
  output logic [NUM_CONV-1:0] schedule,
  output logic [NUM_CHAN-1:0] chanBusy
);
  chanStrobe_t [NUM_CHAN-1:0]         strobe;
  logic [NUM_CHAN-1:0]                kickReq, cntLow, loopsZero;
  logic [NUM_CHAN-1:0][NUM_CHAN-1:0]  chanMask;

  xtrig_control u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .kickReq(kickReq), .cntLow(cntLow), .loopsZero(loopsZero),
    .chanMask(chanMask), .strobe(strobe), .busy(chanBusy)
  );

  xtrig_datapath u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdChan(rdChan), .rdData(rdData), .schedClr(schedClr), .strobe(strobe),
    .kickReq(kickReq), .cntLow(cntLow), .loopsZero(loopsZero),
    .chanMask(chanMask), .schedule(schedule)
  );
endmodule

// File: rtl/xtrig_checker.sv
module xtrig_checker
  import xtrig_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                tickEn,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   wrAddr,
  input logic [DATA_W-1:0]   wrData,
  input logic [DATA_W-1:0]   rdData,
  input logic [NUM_CONV-1:0] schedClr,
  input logic [NUM_CONV-1:0] schedule,
  input logic [NUM_CHAN-1:0] chanBusy
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[KICK_BIT+3:KICK_BIT] == 4'b0000);  // R2

  AST_NO_EVENT_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> ((schedule & ~$past(schedule)) == '0));  // R4

  AST_NO_START_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !tickEn) |=> ((chanBusy & ~$past(chanBusy)) == '0));  // R6

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
    AST_KICK_STARTS: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr[ADDR_W-1:2] == CH_IDX_W'(c) && wrAddr[1] == 1'b0 && wrData[KICK_BIT])
      |=> chanBusy[c]);  // R3
    AST_CLEAR_NO_START: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == {CH_IDX_W'(c), 2'd2} && !chanBusy[c] && !tickEn)
      |=> !chanBusy[c]);  // R3
  end

  for (genvar b = 0; b < NUM_CONV; b++) begin : g_bit
    AST_SCHED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (schedule[b] && !schedClr[b]) |=> schedule[b]);  // R5
  end
endmodule

bind xtrig_delay_bank xtrig_checker u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .rdData(rdData), .schedClr(schedClr), .schedule(schedule),
  .chanBusy(chanBusy)
);

// File: tb/xtrig_delay_bank_test.sv
module xtrig_delay_bank_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        tickEn = 0;
  logic        wrEn = 0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdChan = '0;
  logic [31:0] rdData;
  logic [7:0]  schedClr = 8'hFF;
  logic [7:0]  schedule;
  logic [3:0]  chanBusy;

  int checks = 0;
  int errors = 0;
  int tickCount = 0;

  typedef struct {
    logic [7:0] mask;
    int         tick;
    string      tag;
  } evt_t;
  evt_t expQ[$];

  always #2 clk = ~clk;

  xtrig_delay_bank uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdChan(rdChan), .rdData(rdData), .schedClr(schedClr),
    .schedule(schedule), .chanBusy(chanBusy)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] ch, input logic [1:0] op, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrAddr = {ch, op}; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic readChk(input logic [1:0] ch, input logic [31:0] exp, input string tag);
    rdChan = ch;
    #1;
    check(rdData, exp, tag);
  endtask

  task automatic doTick();
    @(negedge clk);
    tickEn = 1; tickCount++;
    @(negedge clk);
    tickEn = 0;
    @(negedge clk);
  endtask

  task automatic expectEvt(input logic [7:0] mask, input int offs, input string tag);
    evt_t e;
    e.mask = mask; e.tick = tickCount + offs; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compare each new schedule rise with the scoreboard head
  logic [7:0] prevS = '0;
  always @(posedge clk) begin
    #1;
    if (!rstN) prevS = '0;
    else begin
      logic [7:0] rise;
      rise = schedule & ~prevS;
      prevS = schedule;
      if (rise != 0) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL unexpected event: actual=%h expected=none", rise);
        end else begin
          evt_t e;
          e = expQ.pop_front();
          check({24'b0, rise}, {24'b0, e.mask}, {e.tag, " mask"});
          check(tickCount, e.tick, {e.tag, " tick"});
        end
      end
    end
  end

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < 4; c++) readChk(2'(c), 32'h0, "R1 word");
    check({28'b0, chanBusy}, 32'h0, "R1 busy");
    check({24'b0, schedule}, 32'h0, "R1 schedule");

    // R2 write flavours, reserved bits
    wrReg(2'd1, 2'd0, 32'hFFEF_FFFF);
    readChk(2'd1, 32'hFF0F_FFFF, "R2 write");
    wrReg(2'd1, 2'd2, 32'h0000_FFFF);
    readChk(2'd1, 32'hFF0F_0000, "R2 clear");
    wrReg(2'd1, 2'd1, 32'h0000_0123);
    readChk(2'd1, 32'hFF0F_0123, "R2 set");
    wrReg(2'd1, 2'd3, 32'h0F00_0101);
    readChk(2'd1, 32'hF00F_0022, "R2 toggle");
    check({28'b0, chanBusy}, 32'h0, "R2 no start");
    // R3 clear flavour with start bit does not start
    wrReg(2'd1, 2'd2, 32'h0010_0000);
    check({28'b0, chanBusy}, 32'h0, "R3 clear no start");
    wrReg(2'd1, 2'd0, 32'h0);

    // R3/R4 basic countdown of 3
    wrReg(2'd0, 2'd0, 32'h0110_0003);
    check({28'b0, chanBusy}, 32'h1, "R3 busy after kick");
    readChk(2'd0, 32'h0100_0003, "R3 start bit reads 0");
    expectEvt(8'h01, 3, "R4 delay3");
    repeat (4) doTick();
    check({28'b0, chanBusy}, 32'h0, "R9 idle after event");

    // R4 countdown of 0
    wrReg(2'd2, 2'd0, 32'h0410_0000);
    expectEvt(8'h04, 1, "R4 delay0");
    repeat (2) doTick();

    // R8 repeat count 2 -> three events
    wrReg(2'd3, 2'd0, 32'h0810_1002);
    expectEvt(8'h08, 2, "R8 loop1");
    expectEvt(8'h08, 4, "R8 loop2");
    expectEvt(8'h08, 6, "R8 loop3");
    repeat (2) doTick();
    readChk(2'd3, 32'h0800_0802, "R8 repeat field lowered");
    repeat (5) doTick();
    readChk(2'd3, 32'h0800_0002, "R8 repeat field final");
    check({28'b0, chanBusy}, 32'h0, "R9 idle after loops");

    // R6/R10 chain ch0 -> ch1 and ch2
    wrReg(2'd1, 2'd0, 32'h2000_0003);
    wrReg(2'd2, 2'd0, 32'h4000_0003);
    wrReg(2'd0, 2'd0, 32'h1016_0002);
    expectEvt(8'h10, 2, "R6 chain head");
    expectEvt(8'h60, 5, "R10 combined");
    repeat (2) doTick();
    check({28'b0, chanBusy}, 32'h6, "R6 targets busy");
    repeat (4) doTick();
    check({28'b0, chanBusy}, 32'h0, "R9 chain idle");

    // R7 self retrigger
    wrReg(2'd3, 2'd0, 32'h8018_0002);
    expectEvt(8'h80, 2, "R7 self1");
    expectEvt(8'h80, 4, "R7 self2");
    expectEvt(8'h80, 6, "R7 self3");
    repeat (6) doTick();
    check({28'b0, chanBusy}, 32'h8, "R7 still running");
    wrReg(2'd3, 2'd0, 32'h0);
    repeat (3) doTick();
    check({28'b0, chanBusy}, 32'h0, "R7 stopped");

    // R5 sticky schedule
    @(negedge clk); schedClr = 8'h00;
    wrReg(2'd0, 2'd0, 32'h0210_0001);
    expectEvt(8'h02, 1, "R5 sticky event");
    repeat (3) doTick();
    check({24'b0, schedule}, 32'h02, "R5 held");
    @(negedge clk); schedClr = 8'h02;
    @(negedge clk); schedClr = 8'h00;
    check({24'b0, schedule}, 32'h00, "R5 cleared");
    @(negedge clk); schedClr = 8'hFF;

    repeat (4) @(negedge clk);
    check(expQ.size(), 0, "R4 all events seen");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule